// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This unit sits beside a processor's exception sequencer and decides, every clock, whether the interrupt level currently reported as pending is accepted. It also commits the state changes that accepting it implies. The decision is purely combinational. It combines the pending level, the processor's current interrupt level, the raised and enabled interrupt vectors, and a per-level mask table. When the level is accepted, one clock edge saves the return address and status word, builds the new status word, selects the handler address, and emits a one-cycle taken strobe.

Levels two and above are dispatched straight to a per-level handler. Each such level has its own return-address slot and saved-status slot. Level one is handled differently and becomes a general exception. It goes to a user or a kernel handler, chosen by the user-mode bit of the status word. If the exception-mode bit is already set, it becomes a double exception instead. The cause register records the level-one code. Handler addresses come either from a fixed reset base or from a relocatable vector base input, selected at build time.

Top module: `irq_dispatch`

## Requirements
- R1: A pending level P is accepted only when P is strictly greater than `curLevel`, P is no greater than the `NLEVEL` parameter, and the AND of the mask for level P with `intSet` and `intEnable` is nonzero. A pending level of 0 is never accepted.
- R2: The mask for level L (1..NLEVEL) is taken from bits `[(L-1)*IW +: IW]` of `levelMask`. Mask bits of other levels have no influence on the decision for P.
- R3: On accepting a level P >= 2, four things happen. Return slot P (`epcFlat[(P-1)*AW +: AW]`) receives `curPc`. Status slot P (`epsFlat[(P-2)*AW +: AW]`) receives `psIn`. `nextPs` becomes `psIn` with bits [3:0] replaced by P and bit 4 set. `nextPc` becomes the handler of level P.
- R4: On accepting level 1, `excCause` becomes 4 and `nextPs` becomes `psIn` with bit 4 set, all other bits kept.
- R5: On accepting level 1 with `psIn` bit 4 (exception mode) set, `nextPc` becomes the double handler. `curPc` goes to `depcOut` when `HAS_DEPC` is 1; otherwise it goes to return slot 1.
- R6: On accepting level 1 with `psIn` bit 4 clear, `curPc` goes to return slot 1. `nextPc` becomes the user handler when `psIn` bit 5 is set, and the kernel handler otherwise.
- R7: Handler addresses are root + `LVL_VEC_OFS` + P*`LVL_VEC_STRIDE` for level P, and root + `KERNEL_OFS`, root + `USER_OFS` or root + `DOUBLE_OFS` for the others. The root is `vecBase` when `RELOC` is 1 and `RESET_BASE` when it is 0.
- R8: All updates appear after the clock edge at which the decision is true. `takenPulse` is high in exactly the cycle following each accepting edge. An edge without acceptance changes no output.
- R9: While `rstN` is low, every output and every saved slot is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pendLevel | input | 3 | Highest pending interrupt level, 0 when none |
| curLevel | input | 4 | Current interrupt level of the processor |
| intSet | input | IW | Raised interrupt lines |
| intEnable | input | IW | Enabled interrupt lines |
| levelMask | input | NLEVEL*IW | Per-level membership masks, level L at slot L-1 |
| psIn | input | AW | Current status word |
| curPc | input | AW | Address to resume at |
| vecBase | input | AW | Relocatable vector base |
| takenPulse | output | 1 | One-cycle strobe after an accepted interrupt |
| nextPc | output | AW | Handler address of the last accepted interrupt |
| nextPs | output | AW | Status word after the last accepted interrupt |
| epcFlat | output | NLEVEL*AW | Return-address slots 1..NLEVEL |
| epsFlat | output | (NLEVEL-1)*AW | Saved-status slots 2..NLEVEL |
| depcOut | output | AW | Return address of the last double exception |
| excCause | output | 6 | Exception cause register |

## Verification
The bench builds two copies that share one stimulus and an 8-bit interrupt width, so random raised and enabled vectors hit the masks often. The first copy uses five levels, a double-return register and relocation. This brings the upper bound on configured levels within reach: levels 6 and 7 are refused there. It also shows `vecBase` moving every handler. The second copy uses seven levels, no double-return register and a fixed reset base. With it, level-7 slots get written, double exceptions fall back to return slot 1, and `vecBase` is shown to have no effect.

// File: rtl/irq_dispatch_pkg.sv
`timescale 1ns/1ps
package irq_dispatch_pkg;
  localparam int LVL_W   = 3;   // pending level 0..7
  localparam int CUR_W   = 4;   // status-word level field width
  localparam int PS_EXCM = 4;   // exception-mode bit
  localparam int PS_UM   = 5;   // user-mode bit
  localparam int CAUSE_W = 6;
  localparam logic [CAUSE_W-1:0] CAUSE_LVL1 = 6'd4;

  typedef enum logic [1:0] {
    VEC_LEVEL  = 2'd0,
    VEC_KERNEL = 2'd1,
    VEC_USER   = 2'd2,
    VEC_DOUBLE = 2'd3
  } vecSel_e;

  typedef struct packed {
    logic             take;
    logic             highLvl;
    logic             toDepc;
    logic [LVL_W-1:0] level;
    vecSel_e          vecSel;
  } dispCmd_t;
endpackage

// File: rtl/irq_dispatch_ctrl.sv
`timescale 1ns/1ps
module irq_dispatch_ctrl
  import irq_dispatch_pkg::*;
#(
  parameter int NLEVEL   = 7,
  parameter int IW       = 32,
  parameter int HAS_DEPC = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LVL_W-1:0]     pendLevel,
  input  logic [CUR_W-1:0]     curLevel,
  input  logic [IW-1:0]        intSet,
  input  logic [IW-1:0]        intEnable,
  input  logic [NLEVEL*IW-1:0] levelMask,
  input  logic                 psExcm,
  input  logic                 psUm,
  output dispCmd_t             cmd
);
  logic [IW-1:0] maskSel;
  logic          aboveCur;
  logic          withinCfg;
  logic          lineHit;

  // select the mask row of the pending level; rows beyond NLEVEL read as zero
  always_comb begin
    maskSel = '0;
    for (int l = 1; l <= NLEVEL; l++) begin
      if (pendLevel == LVL_W'(l)) maskSel = levelMask[(l-1)*IW +: IW];
    end
  end

  assign aboveCur  = {1'b0, pendLevel} > curLevel;
  assign withinCfg = int'(pendLevel) <= NLEVEL;
  assign lineHit   = |(maskSel & intSet & intEnable);

  always_comb begin
    cmd.take    = aboveCur && withinCfg && lineHit;
    cmd.highLvl = pendLevel > LVL_W'(1);
    cmd.level   = pendLevel;
    cmd.toDepc  = (HAS_DEPC != 0) && psExcm && !cmd.highLvl;
    if (cmd.highLvl)  cmd.vecSel = VEC_LEVEL;
    else if (psExcm)  cmd.vecSel = VEC_DOUBLE;
    else if (psUm)    cmd.vecSel = VEC_USER;
    else              cmd.vecSel = VEC_KERNEL;
  end

  // R1: an accepted request always names a real level above the current one
  p_take_level_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmd.take |-> (cmd.level != '0) && ({1'b0, cmd.level} > curLevel));

  // R5: level one arriving in exception mode is steered to the double handler
  p_lvl1_double_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.take && !cmd.highLvl && psExcm) |-> (cmd.vecSel == VEC_DOUBLE));
endmodule

// File: rtl/irq_dispatch_dp.sv
`timescale 1ns/1ps
module irq_dispatch_dp
  import irq_dispatch_pkg::*;
#(
  parameter int              NLEVEL         = 7,
  parameter int              AW             = 32,
  parameter int              RELOC          = 1,
  parameter logic [AW-1:0]   RESET_BASE     = '0,
  parameter int unsigned     LVL_VEC_OFS    = 32'h100,
  parameter int unsigned     LVL_VEC_STRIDE = 32'h40,
  parameter int unsigned     KERNEL_OFS     = 32'h300,
  parameter int unsigned     USER_OFS       = 32'h340,
  parameter int unsigned     DOUBLE_OFS     = 32'h3C0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dispCmd_t                 cmd,
  input  logic [AW-1:0]            curPc,
  input  logic [AW-1:0]            psIn,
  input  logic [AW-1:0]            vecBase,
  output logic                     takenPulse,
  output logic [AW-1:0]            nextPc,
  output logic [AW-1:0]            nextPs,
  output logic [NLEVEL*AW-1:0]     epcFlat,
  output logic [(NLEVEL-1)*AW-1:0] epsFlat,
  output logic [AW-1:0]            depcOut,
  output logic [CAUSE_W-1:0]       excCause
);
  localparam logic [AW-1:0] EXCM_BIT = AW'(1) << PS_EXCM;

  logic [AW-1:0]   vecRoot;
  logic [AW-1:0]   target;
  logic [AW-1:0]   psNext;
  logic [NLEVEL:1] epcWe;
  logic [NLEVEL:2] epsWe;
  logic [AW-1:0]   epcQ [1:NLEVEL];
  logic [AW-1:0]   epsQ [2:NLEVEL];

  // relocation: configured vector minus reset base plus live base == live base + offset
  generate
    if (RELOC != 0) begin : g_reloc
      assign vecRoot = vecBase;
    end else begin : g_fixed
      assign vecRoot = RESET_BASE;
    end
  endgenerate

  always_comb begin
    unique case (cmd.vecSel)
      VEC_LEVEL:  target = vecRoot + AW'(LVL_VEC_OFS) + AW'(LVL_VEC_STRIDE) * AW'(cmd.level);
      VEC_KERNEL: target = vecRoot + AW'(KERNEL_OFS);
      VEC_USER:   target = vecRoot + AW'(USER_OFS);
      default:    target = vecRoot + AW'(DOUBLE_OFS);
    endcase
  end

  always_comb begin
    if (cmd.highLvl) psNext = {psIn[AW-1:CUR_W], CUR_W'(cmd.level)} | EXCM_BIT;
    else             psNext = psIn | EXCM_BIT;
  end

  always_comb begin
    epcWe = '0;
    for (int s = 1; s <= NLEVEL; s++) begin
      epcWe[s] = cmd.take && ((cmd.highLvl && cmd.level == LVL_W'(s)) ||
                              (s == 1 && !cmd.highLvl && !cmd.toDepc));
    end
    epsWe = '0;
    for (int s = 2; s <= NLEVEL; s++) begin
      epsWe[s] = cmd.take && cmd.highLvl && cmd.level == LVL_W'(s);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takenPulse <= 1'b0;
      nextPc     <= '0;
      nextPs     <= '0;
      depcOut    <= '0;
      excCause   <= '0;
      for (int s = 1; s <= NLEVEL; s++) epcQ[s] <= '0;
      for (int s = 2; s <= NLEVEL; s++) epsQ[s] <= '0;
    end else begin
      takenPulse <= cmd.take;
      if (cmd.take) begin
        nextPc <= target;
        nextPs <= psNext;
        if (!cmd.highLvl) excCause <= CAUSE_LVL1;
        if (cmd.toDepc)   depcOut  <= curPc;
      end
      for (int s = 1; s <= NLEVEL; s++) if (epcWe[s]) epcQ[s] <= curPc;
      for (int s = 2; s <= NLEVEL; s++) if (epsWe[s]) epsQ[s] <= psIn;
    end
  end

  generate
    for (genvar s = 1; s <= NLEVEL; s++) begin : g_epc
      assign epcFlat[(s-1)*AW +: AW] = epcQ[s];
    end
    for (genvar s = 2; s <= NLEVEL; s++) begin : g_eps
      assign epsFlat[(s-2)*AW +: AW] = epsQ[s];
    end
  endgenerate

  // R8: a cycle without the strobe follows an edge that changed nothing
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !takenPulse |-> ($stable(nextPc) && $stable(nextPs) && $stable(excCause) && $stable(depcOut)));

  // R4: every accepted interrupt leaves exception mode set
  p_excm_r4: assert property (@(posedge clk) disable iff (!rstN)
    takenPulse |-> nextPs[PS_EXCM]);

  // R3: a high level lands its own number in the level field
  p_high_ps_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.take && cmd.highLvl) |=> (nextPs[CUR_W-1:0] == $past(CUR_W'(cmd.level))));

  // R4: level one records the level-one cause code
  p_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.take && !cmd.highLvl) |=> (excCause == CAUSE_LVL1));

  // R5: a double exception parks the resume address in the double-return register
  p_depc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.take && cmd.toDepc) |=> (depcOut == $past(curPc)));
endmodule

// File: rtl/irq_dispatch.sv
`timescale 1ns/1ps
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int            NLEVEL         = 7,
  parameter int            IW             = 32,
  parameter int            AW             = 32,
  parameter int            HAS_DEPC       = 1,
  parameter int            RELOC          = 1,
  parameter logic [AW-1:0] RESET_BASE     = AW'(32'h4000_0000),
  parameter int unsigned   LVL_VEC_OFS    = 32'h100,
  parameter int unsigned   LVL_VEC_STRIDE = 32'h40,
  parameter int unsigned   KERNEL_OFS     = 32'h300,
  parameter int unsigned   USER_OFS       = 32'h340,
  parameter int unsigned   DOUBLE_OFS     = 32'h3C0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LVL_W-1:0]         pendLevel,
  input  logic [CUR_W-1:0]         curLevel,
  input  logic [IW-1:0]            intSet,
  input  logic [IW-1:0]            intEnable,
  input  logic [NLEVEL*IW-1:0]     levelMask,
  input  logic [AW-1:0]            psIn,
  input  logic [AW-1:0]            curPc,
  input  logic [AW-1:0]            vecBase,
  output logic                     takenPulse,
  output logic [AW-1:0]            nextPc,
  output logic [AW-1:0]            nextPs,
  output logic [NLEVEL*AW-1:0]     epcFlat,
  output logic [(NLEVEL-1)*AW-1:0] epsFlat,
  output logic [AW-1:0]            depcOut,
  output logic [CAUSE_W-1:0]       excCause
);
  dispCmd_t cmd;

  irq_dispatch_ctrl #(
    .NLEVEL(NLEVEL), .IW(IW), .HAS_DEPC(HAS_DEPC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pendLevel(pendLevel), .curLevel(curLevel),
    .intSet(intSet), .intEnable(intEnable), .levelMask(levelMask),
    .psExcm(psIn[PS_EXCM]), .psUm(psIn[PS_UM]), .cmd(cmd)
  );

  irq_dispatch_dp #(
    .NLEVEL(NLEVEL), .AW(AW), .RELOC(RELOC), .RESET_BASE(RESET_BASE),
    .LVL_VEC_OFS(LVL_VEC_OFS), .LVL_VEC_STRIDE(LVL_VEC_STRIDE),
    .KERNEL_OFS(KERNEL_OFS), .USER_OFS(USER_OFS), .DOUBLE_OFS(DOUBLE_OFS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .curPc(curPc), .psIn(psIn),
    .vecBase(vecBase), .takenPulse(takenPulse), .nextPc(nextPc),
    .nextPs(nextPs), .epcFlat(epcFlat), .epsFlat(epsFlat),
    .depcOut(depcOut), .excCause(excCause)
  );
endmodule

// File: tb/irq_dispatch_test.sv
`timescale 1ns/1ps
module irq_dispatch_test;
  localparam int IW = 8;
  localparam int AW = 32;
  localparam logic [31:0] RB0 = 32'h5000_0000;
  localparam logic [31:0] RB1 = 32'h4000_0000;
  localparam logic [31:0] LOFS = 32'h100, LSTR = 32'h40;
  localparam logic [31:0] KOFS = 32'h300, UOFS = 32'h340, DOFS = 32'h3C0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]    pendLevel = '0;
  logic [3:0]    curLevel = '0;
  logic [IW-1:0] intSet = '0, intEnable = '0;
  logic [IW-1:0] mask [1:7];
  logic [31:0]   psIn = '0, curPc = '0, vecBase = '0;
  logic [5*IW-1:0] maskFlat0;
  logic [7*IW-1:0] maskFlat1;

  always_comb begin
    for (int l = 1; l <= 5; l++) maskFlat0[(l-1)*IW +: IW] = mask[l];
    for (int l = 1; l <= 7; l++) maskFlat1[(l-1)*IW +: IW] = mask[l];
  end

  logic taken0, taken1;
  logic [31:0] pc0, pc1, ps0, ps1, depc0, depc1;
  logic [5:0]  cause0, cause1;
  logic [5*AW-1:0] epcFlat0; logic [4*AW-1:0] epsFlat0;
  logic [7*AW-1:0] epcFlat1; logic [6*AW-1:0] epsFlat1;

  irq_dispatch #(.NLEVEL(5), .IW(IW), .AW(AW), .HAS_DEPC(1), .RELOC(1), .RESET_BASE(RB0),
    .LVL_VEC_OFS(LOFS), .LVL_VEC_STRIDE(LSTR), .KERNEL_OFS(KOFS), .USER_OFS(UOFS),
    .DOUBLE_OFS(DOFS)) uut (
    .clk(clk), .rstN(rstN), .pendLevel(pendLevel), .curLevel(curLevel), .intSet(intSet),
    .intEnable(intEnable), .levelMask(maskFlat0), .psIn(psIn), .curPc(curPc),
    .vecBase(vecBase), .takenPulse(taken0), .nextPc(pc0), .nextPs(ps0),
    .epcFlat(epcFlat0), .epsFlat(epsFlat0), .depcOut(depc0), .excCause(cause0));

  irq_dispatch #(.NLEVEL(7), .IW(IW), .AW(AW), .HAS_DEPC(0), .RELOC(0), .RESET_BASE(RB1),
    .LVL_VEC_OFS(LOFS), .LVL_VEC_STRIDE(LSTR), .KERNEL_OFS(KOFS), .USER_OFS(UOFS),
    .DOUBLE_OFS(DOFS)) uutB (
    .clk(clk), .rstN(rstN), .pendLevel(pendLevel), .curLevel(curLevel), .intSet(intSet),
    .intEnable(intEnable), .levelMask(maskFlat1), .psIn(psIn), .curPc(curPc),
    .vecBase(vecBase), .takenPulse(taken1), .nextPc(pc1), .nextPs(ps1),
    .epcFlat(epcFlat1), .epsFlat(epsFlat1), .depcOut(depc1), .excCause(cause1));

  logic [31:0] dEpc0 [1:7], dEpc1 [1:7], dEps0 [2:7], dEps1 [2:7];
  for (genvar s = 1; s <= 7; s++) begin : g_tapEpc
    if (s <= 5) begin : g_a
      assign dEpc0[s] = epcFlat0[(s-1)*AW +: AW];
    end else begin : g_b
      assign dEpc0[s] = '0;
    end
    assign dEpc1[s] = epcFlat1[(s-1)*AW +: AW];
  end
  for (genvar s = 2; s <= 7; s++) begin : g_tapEps
    if (s <= 5) begin : g_a
      assign dEps0[s] = epsFlat0[(s-2)*AW +: AW];
    end else begin : g_b
      assign dEps0[s] = '0;
    end
    assign dEps1[s] = epsFlat1[(s-2)*AW +: AW];
  end

  // behavioural reference model, one state set per copy
  logic        mTaken [0:1];
  logic [31:0] mPc [0:1], mPs [0:1], mDepc [0:1];
  logic [5:0]  mCause [0:1];
  logic [31:0] mEpc [0:1][1:7];
  logic [31:0] mEps [0:1][2:7];

  task automatic modelReset();
    for (int k = 0; k < 2; k++) begin
      mTaken[k] = 0; mPc[k] = 0; mPs[k] = 0; mDepc[k] = 0; mCause[k] = 0;
      for (int s = 1; s <= 7; s++) mEpc[k][s] = 0;
      for (int s = 2; s <= 7; s++) mEps[k][s] = 0;
    end
  endtask

  task automatic modelStep(input int k);
    int nl = (k == 0) ? 5 : 7;
    bit hasDepc = (k == 0);
    logic [31:0] root = (k == 0) ? vecBase : RB1;
    int p = int'(pendLevel);
    bit ok = (p > int'(curLevel)) && (p <= nl) && ((mask[p == 0 ? 1 : p] & intSet & intEnable) != 0);
    mTaken[k] = ok;
    if (!ok) return;
    if (p > 1) begin
      mEpc[k][p] = curPc;
      mEps[k][p] = psIn;
      mPs[k] = (psIn & ~32'hF) | 32'(p) | 32'h10;
      mPc[k] = root + LOFS + LSTR * 32'(p);
    end else begin
      mCause[k] = 6'd4;
      if (psIn[4]) begin
        if (hasDepc) mDepc[k] = curPc; else mEpc[k][1] = curPc;
        mPc[k] = root + DOFS;
      end else begin
        mEpc[k][1] = curPc;
        mPc[k] = root + (psIn[5] ? UOFS : KOFS);
      end
      mPs[k] = psIn | 32'h10;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      modelStep(0);
      modelStep(1);
    end
  end

  int checks = 0, fails = 0;
  string curTag = "R9";
  bit done = 0;

  task automatic checkVal(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", curTag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    checkVal("uut taken", 32'(taken0), 32'(mTaken[0]));
    checkVal("uutB taken", 32'(taken1), 32'(mTaken[1]));
    checkVal("uut nextPc", pc0, mPc[0]);
    checkVal("uutB nextPc", pc1, mPc[1]);
    checkVal("uut nextPs", ps0, mPs[0]);
    checkVal("uutB nextPs", ps1, mPs[1]);
    checkVal("uut cause", 32'(cause0), 32'(mCause[0]));
    checkVal("uutB cause", 32'(cause1), 32'(mCause[1]));
    checkVal("uut depc", depc0, mDepc[0]);
    checkVal("uutB depc", depc1, mDepc[1]);
    for (int s = 1; s <= 7; s++) begin
      if (s <= 5) checkVal($sformatf("uut epc%0d", s), dEpc0[s], mEpc[0][s]);
      checkVal($sformatf("uutB epc%0d", s), dEpc1[s], mEpc[1][s]);
    end
    for (int s = 2; s <= 7; s++) begin
      if (s <= 5) checkVal($sformatf("uut eps%0d", s), dEps0[s], mEps[0][s]);
      checkVal($sformatf("uutB eps%0d", s), dEps1[s], mEps[1][s]);
    end
  endtask

  task automatic apply(input string tag, input int p, input int cur, input logic [7:0] iset,
                       input logic [7:0] ien, input logic [31:0] ps, input logic [31:0] pc);
    pendLevel = 3'(p); curLevel = 4'(cur); intSet = iset; intEnable = ien;
    psIn = ps; curPc = pc;
    @(negedge clk);
    curTag = tag;
    compareAll();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int l = 1; l <= 7; l++) mask[l] = 8'(1 << (l - 1));
    vecBase = 32'h2000_0000;
    repeat (3) @(negedge clk);
    curTag = "R9"; compareAll();
    rstN = 1'b1;
    @(negedge clk); curTag = "R9"; compareAll();

    // R1: refusal conditions
    apply("R1", 0, 0, 8'hFF, 8'hFF, 32'h0, 32'h100);
    apply("R1", 3, 3, 8'hFF, 8'hFF, 32'h0, 32'h104);
    apply("R1", 3, 4, 8'hFF, 8'hFF, 32'h0, 32'h108);
    apply("R1", 3, 2, 8'hFF, 8'h00, 32'h0, 32'h10C);
    apply("R1", 3, 2, 8'h00, 8'hFF, 32'h0, 32'h110);
    apply("R1", 3, 2, 8'h04, 8'hFF, 32'h0, 32'h114);
    apply("R1", 6, 0, 8'h20, 8'hFF, 32'h0, 32'h118);
    apply("R1", 7, 0, 8'h40, 8'hFF, 32'h0, 32'h11C);
    apply("R1", 1, 1, 8'h01, 8'hFF, 32'h0, 32'h120);
    // R2: only the pending level's own mask row counts
    apply("R2", 4, 0, 8'h04, 8'hFF, 32'h0, 32'h200);
    apply("R2", 4, 0, 8'h80, 8'hFF, 32'h0, 32'h204);
    apply("R2", 4, 0, 8'h08, 8'hFF, 32'h0, 32'h208);
    // R3: every high level
    for (int l = 2; l <= 7; l++)
      apply("R3", l, 0, 8'hFF, 8'hFF, 32'hABCD_0E00 | 32'(l - 1), 32'h3000 + 32'(l * 4));
    // R6 / R4: level one outside exception mode
    apply("R6", 1, 0, 8'h01, 8'hFF, 32'h0000_0000, 32'h400);
    apply("R6", 1, 0, 8'h01, 8'hFF, 32'h0000_0020, 32'h404);
    apply("R4", 1, 0, 8'h01, 8'hFF, 32'hF0F0_F0C3, 32'h408);
    // R5: level one in exception mode
    apply("R5", 1, 0, 8'h01, 8'hFF, 32'h0000_0010, 32'h500);
    apply("R5", 1, 0, 8'h01, 8'hFF, 32'h0000_0030, 32'h504);
    // R7: moving the vector base
    vecBase = 32'h6000_0000;
    apply("R7", 2, 1, 8'h02, 8'hFF, 32'h0, 32'h600);
    apply("R7", 1, 0, 8'h01, 8'hFF, 32'h0, 32'h604);
    apply("R7", 1, 0, 8'h01, 8'hFF, 32'h10, 32'h608);
    // R8: back-to-back takes, then idle edges
    apply("R8", 5, 0, 8'h10, 8'hFF, 32'h0, 32'h700);
    apply("R8", 5, 0, 8'h10, 8'hFF, 32'h0, 32'h704);
    apply("R8", 0, 0, 8'hFF, 8'hFF, 32'h77, 32'h708);
    apply("R8", 5, 6, 8'hFF, 8'hFF, 32'h55, 32'h70C);
    apply("R8", 2, 0, 8'h02, 8'hFF, 32'h0, 32'h710);
    // R8 / R1: random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      if (i % 50 == 0) vecBase = $urandom & 32'hFFFF_F000;
      apply("R8", int'(r[2:0]), int'(r[6:4]), 8'($urandom), 8'($urandom), $urandom, $urandom);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule